// File: doc/BRIEF.md
# Prioritized Interrupt Status Encoder

This block sits between the interrupt sources of a serial port and the processor-visible status byte. It takes five source conditions: a line-status error, receive data available at the trigger level, a receive timeout, an empty transmit holding register and a modem-status change. Each source is gated by its own enable. Only the highest-ranked pending source is reported, as a four-bit code in the low nibble of an eight-bit status byte. An active-high interrupt request line follows the "pending" state of that byte.

Software reads the byte with a read strobe. The byte is frozen while the strobe is high, so a read always sees one consistent value. A read that reports the transmit-empty source clears that source's pending flag. The line-status, receive and modem sources stay pending until their condition goes away. Once the reported source is gone, the next read shows the next lower pending source. The upper two bits show whether the FIFOs are enabled.

Top module: `irq_status_enc`

## Requirements
- R1: Ranking from highest to lowest is line status, then receive (data or timeout), then transmit holding empty, then modem status; only the highest pending source is reported.
- R2: Bits 3:0 read 0110 for line status, 0100 for receive data, 1100 for receive timeout, 0010 for transmit empty and 0000 for modem status; when timeout and data are both pending, the timeout code is reported.
- R3: With nothing pending, bits 3:0 read 0001; `status` is 8'h01 during reset; `irq` is always the inverse of status bit 0.
- R4: Bits 5:4 always read 00.
- R5: Bits 7:6 read 11 when `fifo_on` is high and 00 when it is low.
- R6: A source counts only when its enable is set: `src_en[0]` gates receive data and timeout, `src_en[1]` gates transmit empty, `src_en[2]` gates line status and `src_en[3]` gates modem status.
- R7: While `rd_stb` is high, `status` holds the value it had in the cycle before `rd_stb` rose, whatever the inputs do.
- R8: A read whose captured code is 0010 (transmit empty) clears the transmit-empty pending flag, so a lower pending source is reported after the read.
- R9: A read does not clear line-status, receive or modem interrupts; these remain reported until their condition or enable drops.
- R10: The transmit-empty flag is set when `thr_empty` and `src_en[1]` become high together, and it is dropped whenever that combined level is low; a level that simply stays high does not set the flag again after a read.
- R11: When no read is in progress, `status` reflects a change in a level source one clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| line_err | input | 1 | Line-status error condition |
| rx_ready | input | 1 | Receive data at trigger level |
| rx_timeout | input | 1 | Receive timeout condition |
| thr_empty | input | 1 | Transmit holding register empty |
| modem_chg | input | 1 | Modem-status change condition |
| src_en | input | 4 | Source enables (0 receive, 1 transmit, 2 line, 3 modem) |
| fifo_on | input | 1 | FIFOs enabled |
| rd_stb | input | 1 | Status read strobe |
| status | output | 8 | Status byte |
| irq | output | 1 | Interrupt request, high when pending |

## Verification
On every cycle, the assertions check the following: the byte stays frozen during a read strobe, the line-status and timeout codes win one edge after their condition appears, the idle code appears when nothing is enabled and pending, the FIFO bits follow the flag, and a read reporting transmit-empty clears that flag. Some behaviour only the bench scenarios can show. This includes walking down the ranking by successive reads and clearing sources, the fact that a steady transmit-empty level does not set the flag again, and enable gating over random mixes of sources. It also includes the one-edge lag of the byte behind its inputs.

// File: rtl/irq_status_enc.sv
module irq_status_enc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_err,
  input  logic       rx_ready,
  input  logic       rx_timeout,
  input  logic       thr_empty,
  input  logic       modem_chg,
  input  logic [3:0] src_en,
  input  logic       fifo_on,
  input  logic       rd_stb,
  output logic [7:0] status,
  output logic       irq
);

  localparam logic [3:0] C_LINE = 4'b0110;
  localparam logic [3:0] C_DATA = 4'b0100;
  localparam logic [3:0] C_TMO  = 4'b1100;
  localparam logic [3:0] C_THR  = 4'b0010;
  localparam logic [3:0] C_MDM  = 4'b0000;
  localparam logic [3:0] C_NONE = 4'b0001;

  logic       p_line, p_data, p_tmo, p_mdm;
  logic       thr_lvl, thr_lvl_q, thr_pend, rd_q, rd_rise;
  logic [3:0] code;
  logic [7:0] live, stat_q;

  assign p_line  = line_err   & src_en[2];
  assign p_data  = rx_ready   & src_en[0];
  assign p_tmo   = rx_timeout & src_en[0];
  assign p_mdm   = modem_chg  & src_en[3];
  assign thr_lvl = thr_empty  & src_en[1];
  assign rd_rise = rd_stb & ~rd_q;

  always_comb begin
    if (p_line)        code = C_LINE;
    else if (p_tmo)    code = C_TMO;
    else if (p_data)   code = C_DATA;
    else if (thr_pend) code = C_THR;
    else if (p_mdm)    code = C_MDM;
    else               code = C_NONE;
  end

  assign live = {{2{fifo_on}}, 2'b00, code};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q    <= 8'h01;
      rd_q      <= 1'b0;
      thr_lvl_q <= 1'b0;
      thr_pend  <= 1'b0;
    end else begin
      rd_q      <= rd_stb;
      thr_lvl_q <= thr_lvl;
      if (!rd_stb) stat_q <= live;
      if (!thr_lvl)                                 thr_pend <= 1'b0;
      else if (!thr_lvl_q)                          thr_pend <= 1'b1;
      else if (rd_rise && stat_q[3:0] == C_THR)     thr_pend <= 1'b0;
    end
  end

  assign status = stat_q;
  assign irq    = ~stat_q[0];

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && rd_q |=> $stable(status));

  // R1
  line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_line && !rd_stb |=> status[3:0] == C_LINE);

  // R2
  tmo_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_tmo && !p_line && !rd_stb |=> status[3:0] == C_TMO);

  // R3
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb && !p_line && !p_data && !p_tmo && !p_mdm && !thr_pend
      |=> status[0] && irq == 1'b0);

  // R5
  fifo_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> status[7:6] == {2{$past(fifo_on)}});

  // R8
  thr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise && status[3:0] == C_THR && thr_lvl_q |=> !thr_pend);

endmodule

// File: tb/irq_status_enc_tb.sv
`timescale 1ns/1ps
module irq_status_enc_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_err = 0, rx_ready = 0, rx_timeout = 0, thr_empty = 0, modem_chg = 0;
  logic [3:0] src_en = 4'h0;
  logic       fifo_on = 0, rd_stb = 0;
  logic [7:0] status;
  logic       irq;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic m_thr = 0, m_prev = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_status_enc u_dut (
    .clk(clk), .rst_n(rst_n), .line_err(line_err), .rx_ready(rx_ready),
    .rx_timeout(rx_timeout), .thr_empty(thr_empty), .modem_chg(modem_chg),
    .src_en(src_en), .fifo_on(fifo_on), .rd_stb(rd_stb),
    .status(status), .irq(irq)
  );

  function automatic logic [7:0] exp_f();
    logic [3:0] c;
    if (line_err & src_en[2])        c = 4'b0110;
    else if (rx_timeout & src_en[0]) c = 4'b1100;
    else if (rx_ready & src_en[0])   c = 4'b0100;
    else if (m_thr)                  c = 4'b0010;
    else if (modem_chg & src_en[3])  c = 4'b0000;
    else                             c = 4'b0001;
    return {{2{fifo_on}}, 2'b00, c};
  endfunction

  function automatic string req_of(logic [3:0] c);
    case (c)
      4'b0110: return "R1 line";
      4'b1100: return "R2 timeout";
      4'b0100: return "R2 data";
      4'b0010: return "R10 thr";
      4'b0000: return "R9 modem";
      default: return "R3 idle";
    endcase
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h at cycle %0d", req, got, exp, cyc);
    end
  endtask

  task automatic model_thr();
    logic lvl;
    lvl = thr_empty & src_en[1];
    if (!lvl) m_thr = 0;
    else if (!m_prev) m_thr = 1;
    m_prev = lvl;
  endtask

  task automatic settle_check(string tag);
    model_thr();
    repeat (3) @(negedge clk);
    check({tag, " ", req_of(exp_f() >> 0)}, status, exp_f());
    check("R3 irq", {7'd0, irq}, {7'd0, ~exp_f() & 8'h01} & 8'h01);
    check("R4 zero bits", {6'd0, status[5:4]}, 8'h00);
  endtask

  task automatic do_read(output logic [7:0] pre);
    pre = status;
    rd_stb = 1;
    @(negedge clk);
    check("R7 hold", status, pre);
    @(negedge clk);
    check("R7 hold", status, pre);
    rd_stb = 0;
    if (pre[3:0] == 4'b0010) m_thr = 0;
  endtask

  task automatic drive(logic l, logic r, logic t, logic h, logic m, logic [3:0] e, logic f);
    line_err = l; rx_ready = r; rx_timeout = t; thr_empty = h; modem_chg = m;
    src_en = e; fifo_on = f;
  endtask

  initial begin
    wait (cyc == 100000);
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] pre;
    int seed_v;
    seed_v = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    check("R3 reset value", status, 8'h01);
    check("R3 reset irq", {7'd0, irq}, 8'h00);
    rst_n = 1;
    @(negedge clk);

    // R1 ranking and R9 reads that do not clear
    drive(1, 1, 0, 1, 1, 4'hF, 1);
    settle_check("R1");
    check("R1 line wins", status, 8'hC6);
    do_read(pre);
    settle_check("R9");
    check("R9 line kept after read", status, 8'hC6);
    line_err = 0;
    settle_check("R1");
    check("R1 data next", status, 8'hC4);
    rx_ready = 0;
    settle_check("R1");
    check("R1 thr next", status, 8'hC2);
    do_read(pre);
    settle_check("R8");
    check("R8 modem after thr read", status, 8'hC0);
    do_read(pre);
    settle_check("R9");
    check("R9 modem kept", status, 8'hC0);
    fifo_on = 0;
    settle_check("R5");
    check("R5 fifo off", status, 8'h00);
    // R10 steady level does not set the flag again
    modem_chg = 0;
    settle_check("R10");
    check("R10 no re-set", status, 8'h01);
    thr_empty = 0;
    settle_check("R10");
    thr_empty = 1;
    settle_check("R10");
    check("R10 new rise", status, 8'h02);
    thr_empty = 0;
    settle_check("R10");
    check("R10 level drop clears", status, 8'h01);

    // R2 timeout over data
    drive(0, 1, 1, 0, 0, 4'hF, 1);
    settle_check("R2");
    check("R2 timeout code", status, 8'hCC);
    // R6 enable gating
    drive(1, 1, 1, 1, 1, 4'h0, 1);
    settle_check("R6");
    check("R6 all masked", status, 8'hC1);
    src_en = 4'b1000;
    settle_check("R6");
    check("R6 modem only", status, 8'hC0);

    // R7 freeze while inputs change
    drive(0, 0, 0, 0, 0, 4'hF, 1);
    settle_check("R7");
    rd_stb = 1;
    @(negedge clk);
    line_err = 1;
    @(negedge clk);
    check("R7 frozen", status, 8'hC1);
    @(negedge clk);
    check("R7 frozen", status, 8'hC1);
    rd_stb = 0;
    @(negedge clk);
    check("R11 one edge after read", status, 8'hC6);

    // R11 one-edge lag
    drive(0, 0, 0, 0, 0, 4'hF, 0);
    settle_check("R11");
    modem_chg = 1;
    @(negedge clk);
    check("R11 one edge lag", status, 8'h00);

    // random mix
    for (int i = 0; i < 400; i++) begin
      drive(($urandom % 10) < 2, ($urandom % 10) < 3, ($urandom % 10) < 2,
            ($urandom % 10) < 5, ($urandom % 10) < 4,
            4'($urandom), $urandom % 2);
      settle_check("random");
      if ($urandom % 3 == 0) begin
        do_read(pre);
        settle_check("R8/R9 random after read");
      end
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule